// File: doc/BRIEF.md
# Test Instruction Decoder and Data-Path Router

This block sits behind a test access port controller and turns the active 4-bit test instruction into the control signals used by the rest of the test logic. It holds the active instruction, loading a new code from the instruction shift chain when the controller pulses its update-instruction strobe. From that code it chooses which data register is placed between the serial test input and the serial test output: the external boundary-scan chain, a one-bit pass-through register, or an identification register whose width and contents are parameters.

It also owns the pass-through and identification registers, which react to the capture, shift and update strobes of the data-register path, and it produces three pin-control outputs: a test-mode flag for the boundary cells, a global output-driver disable, and a select that makes pins take their data from the boundary update latches. The controller state machine and the instruction shift chain live elsewhere; this block sees only their strobes, all sampled on the rising test clock.

Top module: `jtag_instr_route`

## Requirements
- R1: Exactly one path select is high. Codes 0000 (external test), 0011 (sample/preload) and 1100 (internal test) select the boundary chain; 1110 selects the identification register; 0101, 0111, 1001, 1111 and every code not listed here select the pass-through register.
- R2: The serial output `tdo` equals `bsr_so` when the boundary chain is selected, the pass-through bit when that register is selected, and bit 0 of the identification register when it is selected.
- R3: `cell_test` is high only for codes 0000 and 1100.
- R4: `pin_hold` is high only for codes 0101 (clamp) and 1001 (clamp with drivers off), making pins take boundary update-latch data.
- R5: `drv_off` is high only for codes 0111 (drivers off) and 1001.
- R6: Any code not listed in R1 behaves exactly like 1111: pass-through path and no mode, hold or disable output high.
- R7: The active instruction (`cur_ir`) takes `ir_value` at a rising clock edge where `ir_update` is high and keeps its value otherwise; `ir_value` has no effect at other edges.
- R8: While `rst_n` is low, the active instruction is 1110, the identification path is selected, `cell_test`, `pin_hold` and `drv_off` are low, and the identification register holds the identification code.
- R9: With the pass-through path selected, a capture edge loads 0, and a shift edge loads `tdi`, so data appears on `tdo` one clock later.
- R10: The pass-through bit does not change at an update edge or at any edge where its path is not selected.
- R11: With the identification path selected, a capture edge loads the identification code (bit 0 is always 1), and a shift edge moves the register one place toward bit 0 with `tdi` entering the top bit.
- R12: The identification register does not change at an update edge or at any edge where its path is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low test-logic reset |
| ir_value | input | 4 | Parallel value of the instruction shift chain |
| ir_update | input | 1 | Update-instruction strobe |
| dr_capture | input | 1 | Capture strobe of the data-register path |
| dr_shift | input | 1 | Shift strobe of the data-register path |
| dr_update | input | 1 | Update strobe of the data-register path |
| tdi | input | 1 | Serial test data input |
| bsr_so | input | 1 | Serial output of the external boundary-scan chain |
| cur_ir | output | 4 | Active instruction code |
| sel_bsr | output | 1 | Boundary chain is the selected data path |
| sel_byp | output | 1 | Pass-through register is the selected data path |
| sel_id | output | 1 | Identification register is the selected data path |
| cell_test | output | 1 | Boundary cells in test mode |
| pin_hold | output | 1 | Pins driven from boundary update-latch data |
| drv_off | output | 1 | All output drivers disabled |
| tdo | output | 1 | Serial output of the selected data register |

## Verification
The register assertions take for granted that the controller raises at most one of the four strobes in a cycle, since a state machine is only ever in one state; the pass-through and identification checks would be ambiguous if capture and shift met. The stimulus keeps to this by driving each cycle from a single chosen action: load an instruction, capture, shift, update or idle. Every instruction code, including two undefined ones, is loaded in turn and walked through a full capture, shift longer than the identification register, update and further shift, with instruction values changed without the load strobe and a pass-through bit carried across a detour through another path.

// File: rtl/jir_pkg.sv
package jir_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_EXT     = 4'b0000,
      OP_SAMPLE  = 4'b0011,
      OP_HOLD    = 4'b0101,
      OP_FLOAT   = 4'b0111,
      OP_HOLDOFF = 4'b1001,
      OP_INT     = 4'b1100,
      OP_IDENT   = 4'b1110,
      OP_PASS    = 4'b1111
   } op_e;

   typedef enum logic [1:0] {
      PATH_CHAIN = 2'd0,
      PATH_PASS  = 2'd1,
      PATH_IDENT = 2'd2
   } path_e;

   typedef struct packed {
      path_e path;
      logic  test;
      logic  hold;
      logic  off;
   } ctl_t;

endpackage

// File: rtl/jir_decode.sv
module jir_decode
   import jir_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output ctl_t            ctl
);

   always_comb begin
      ctl = '{path: PATH_PASS, test: 1'b0, hold: 1'b0, off: 1'b0};
      case (op)
         OP_EXT:     begin ctl.path = PATH_CHAIN; ctl.test = 1'b1; end
         OP_INT:     begin ctl.path = PATH_CHAIN; ctl.test = 1'b1; end
         OP_SAMPLE:  ctl.path = PATH_CHAIN;
         OP_IDENT:   ctl.path = PATH_IDENT;
         OP_HOLD:    ctl.hold = 1'b1;
         OP_FLOAT:   ctl.off  = 1'b1;
         OP_HOLDOFF: begin ctl.hold = 1'b1; ctl.off = 1'b1; end
         default:    ctl.path = PATH_PASS;
      endcase
   end

endmodule

// File: rtl/jir_pass_reg.sv
module jir_pass_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic cap,
   input  logic sh,
   input  logic din,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (cap) q <= 1'b0;
      else if (sh)  q <= din;
   end

   assert_cap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (q == 1'b0));
   assert_shift_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && !cap) |=> (q == $past(din)));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap && !sh) |=> $stable(q));

endmodule

// File: rtl/jir_ident_reg.sv
module jir_ident_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] CODE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         sh,
   input  logic         din,
   output logic [W-1:0] q,
   output logic         so
);

   if (W < 2) begin : g_bad_width
      $error("identification register needs at least two bits");
   end
   if (CODE[0] != 1'b1) begin : g_bad_code
      $error("identification code bit 0 must be 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= CODE;
      else if (cap) q <= CODE;
      else if (sh)  q <= {din, q[W-1:1]};
   end

   assign so = q[0];

   assert_cap_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (q == CODE));
   assert_shift_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && !cap) |=> (q[W-1] == $past(din)));
   assert_shift_body_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && !cap) |=> (q[W-2:0] == $past(q[W-1:1])));
   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap && !sh) |=> $stable(q));

endmodule

// File: rtl/jtag_instr_route.sv
module jtag_instr_route
   import jir_pkg::*;
#(
   parameter int               IR_W    = 4,
   parameter int               ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_CODE = 32'h1A5C_3E27
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IR_W-1:0] ir_value,
   input  logic            ir_update,
   input  logic            dr_capture,
   input  logic            dr_shift,
   input  logic            dr_update,
   input  logic            tdi,
   input  logic            bsr_so,
   output logic [IR_W-1:0] cur_ir,
   output logic            sel_bsr,
   output logic            sel_byp,
   output logic            sel_id,
   output logic            cell_test,
   output logic            pin_hold,
   output logic            drv_off,
   output logic            tdo
);

   if (IR_W != OP_W) begin : g_bad_ir
      $error("instruction width must match the decoded code width");
   end

   localparam logic [IR_W-1:0] RESET_OP = IR_W'(OP_IDENT);

   ctl_t            ctl;
   logic            pass_q;
   logic [ID_W-1:0] ident_q;
   logic            ident_so;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cur_ir <= RESET_OP;
      else if (ir_update) cur_ir <= ir_value;
   end

   jir_decode u_dec (
      .op  (cur_ir[OP_W-1:0]),
      .ctl (ctl)
   );

   assign sel_bsr   = (ctl.path == PATH_CHAIN);
   assign sel_byp   = (ctl.path == PATH_PASS);
   assign sel_id    = (ctl.path == PATH_IDENT);
   assign cell_test = ctl.test;
   assign pin_hold  = ctl.hold;
   assign drv_off   = ctl.off;

   jir_pass_reg u_pass (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (dr_capture & sel_byp),
      .sh    (dr_shift & sel_byp),
      .din   (tdi),
      .q     (pass_q)
   );

   jir_ident_reg #(.W(ID_W), .CODE(ID_CODE)) u_ident (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (dr_capture & sel_id),
      .sh    (dr_shift & sel_id),
      .din   (tdi),
      .q     (ident_q),
      .so    (ident_so)
   );

   always_comb begin
      unique case (1'b1)
         sel_bsr: tdo = bsr_so;
         sel_id:  tdo = ident_so;
         default: tdo = pass_q;
      endcase
   end

   assert_onehot_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({sel_bsr, sel_byp, sel_id}));
   assert_chain_tdo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_bsr |-> (tdo == bsr_so));
   assert_test_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cell_test |-> (sel_bsr && !drv_off && !pin_hold));
   assert_pin_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hold || drv_off) |-> sel_byp);
   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ir_update |=> (cur_ir == $past(ir_value)));
   assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_update |=> $stable(cur_ir));
   assert_ident_unused_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_id |=> $stable(ident_q));

endmodule

// File: tb/sim_jtag_instr_route.sv
module sim_jtag_instr_route;

   localparam logic [31:0] CODE = 32'h1A5C_3E27;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [3:0] ir_value = 4'b0;
   logic       ir_update = 1'b0, dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
   logic       tdi = 1'b0, bsr_so = 1'b0;
   logic [3:0] cur_ir;
   logic       sel_bsr, sel_byp, sel_id, cell_test, pin_hold, drv_off, tdo;

   jtag_instr_route #(.IR_W(4), .ID_W(32), .ID_CODE(CODE)) u0 (
      .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .ir_update(ir_update),
      .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
      .tdi(tdi), .bsr_so(bsr_so), .cur_ir(cur_ir), .sel_bsr(sel_bsr),
      .sel_byp(sel_byp), .sel_id(sel_id), .cell_test(cell_test),
      .pin_hold(pin_hold), .drv_off(drv_off), .tdo(tdo)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   logic [3:0]  m_ir  = 4'b1110;
   logic        m_pass = 1'b0;
   logic [31:0] m_id  = CODE;
   bit          m_upd_last = 1'b0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int path_of(input logic [3:0] c);
      case (c)
         4'b0000, 4'b0011, 4'b1100: return 0;
         4'b1110:                   return 2;
         default:                   return 1;
      endcase
   endfunction

   function automatic bit known(input logic [3:0] c);
      case (c)
         4'b0000, 4'b0011, 4'b0101, 4'b0111, 4'b1001, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic compare();
      int p = path_of(m_ir);
      bit k = known(m_ir);
      chk(k ? "R1" : "R6", "select", {29'd0, sel_bsr, sel_byp, sel_id},
          (p == 0) ? 32'd4 : (p == 1) ? 32'd2 : 32'd1);
      chk(k ? "R3" : "R6", "cell_test", cell_test, (m_ir == 4'b0000 || m_ir == 4'b1100));
      chk(k ? "R4" : "R6", "pin_hold", pin_hold, (m_ir == 4'b0101 || m_ir == 4'b1001));
      chk(k ? "R5" : "R6", "drv_off", drv_off, (m_ir == 4'b0111 || m_ir == 4'b1001));
      chk("R7", "cur_ir", cur_ir, m_ir);
      if (p == 0)      chk("R2", "tdo chain", tdo, bsr_so);
      else if (p == 1) chk(m_upd_last ? "R10" : "R9", "tdo pass", tdo, m_pass);
      else             chk(m_upd_last ? "R12" : "R11", "tdo ident", tdo, m_id[0]);
   endtask

   task automatic step(input logic [3:0] iv, input bit ui, input bit cp, input bit sh,
                       input bit up, input bit t, input bit b);
      int p;
      @(negedge clk);
      ir_value = iv; ir_update = ui; dr_capture = cp; dr_shift = sh; dr_update = up;
      tdi = t; bsr_so = b;
      #1 compare();
      @(posedge clk);
      p = path_of(m_ir);
      if (cp) begin
         if (p == 1) m_pass = 1'b0;
         if (p == 2) m_id = CODE;
      end else if (sh) begin
         if (p == 1) m_pass = t;
         if (p == 2) m_id = {t, m_id[31:1]};
      end
      if (ui) m_ir = iv;
      m_upd_last = up;
   endtask

   task automatic idle();
      step(4'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'($urandom), 1'($urandom));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] codes [10] = '{4'b0000, 4'b0011, 4'b0101, 4'b0111, 4'b1001,
                                 4'b1100, 4'b1110, 4'b1111, 4'b0001, 4'b1010};
      // R8: reset state
      repeat (2) @(negedge clk);
      #1;
      chk("R8", "reset cur_ir", cur_ir, 4'b1110);
      chk("R8", "reset select", {sel_bsr, sel_byp, sel_id}, 3'b001);
      chk("R8", "reset modes", {cell_test, pin_hold, drv_off}, 3'b000);
      chk("R8", "reset tdo", tdo, CODE[0]);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: identification shift straight after reset
      for (int i = 0; i < 8; i++) step(4'b0, 0, 0, 1, 0, 1'($urandom), 1'b0);

      foreach (codes[c]) begin
         step(codes[c], 1, 0, 0, 0, 1'b0, 1'b0);         // load
         idle(); idle();                                 // R7: ir_value ignored
         step(4'b0, 0, 1, 0, 0, 1'($urandom), 1'($urandom));
         for (int i = 0; i < 36; i++)
            step(4'($urandom), 0, 0, 1, 0, 1'($urandom), 1'($urandom));
         step(4'b0, 0, 0, 0, 1, 1'($urandom), 1'($urandom)); // update
         idle();
         step(4'b0, 0, 1, 0, 0, 1'b1, 1'($urandom));         // capture again
         for (int i = 0; i < 3; i++)
            step(4'b0, 0, 0, 1, 0, 1'($urandom), 1'($urandom));
      end

      // R10: pass-through bit kept while another path is used
      step(4'b1111, 1, 0, 0, 0, 1'b0, 1'b0);
      step(4'b0, 0, 0, 1, 0, 1'b1, 1'b0);
      step(4'b1110, 1, 0, 0, 0, 1'b0, 1'b0);
      step(4'b0, 0, 1, 0, 0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(4'b0, 0, 0, 1, 0, 1'b0, 1'b0);
      step(4'b1111, 1, 0, 0, 0, 1'b0, 1'b0);
      step(4'b0, 0, 0, 0, 1, 1'b0, 1'b0);
      idle();
      // R12: identification register kept across a chain detour
      step(4'b0000, 1, 0, 0, 0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) step(4'b0, 0, 0, 1, 0, 1'($urandom), 1'($urandom));
      step(4'b1110, 1, 0, 0, 0, 1'b0, 1'b0);
      idle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule